// File: doc/BRIEF.md
# Hamming Single-Bit ECC Corrector for 512-Byte Chunks

This block settles the integrity of one 512-byte chunk from two 24-bit Hamming codes: the code kept with the chunk in the spare area, and the code computed over the data just read. The kept code is held in complemented form, so the block inverts it before the compare. Each code has two 12-bit halves. Both halves go through XOR to give an odd syndrome and an even syndrome. From these two syndromes the block sorts the chunk into one of four outcomes: clean, one flipped data bit, one flipped parity bit, or damage it cannot repair.

When one data bit is wrong, the block repairs the buffer itself. It reads the affected byte through a RAM port with one cycle of read latency, toggles the bad bit and writes the byte back. It raises `done` with the outcome only once that write has landed. Two running totals record the outcomes: one counts repaired errors and one counts chunks that could not be repaired. A single-cycle clear pulse resets both totals.

Top module: `ecc_corrector`

## Requirements
- R1: While reset is held and on leaving it, `busy`, `done`, `mem_rd` and `mem_wr` are low, `status` is 2'b00, and both counters are zero.
- R2: The kept code is complemented before use. The odd syndrome is bits [11:0] and the even syndrome is bits [23:12] of (~stored_code ^ calc_code).
- R3: If both syndromes are zero, `status` is 2'b00 (clean) and the buffer is not accessed.
- R4: If the odd syndrome equals the 12-bit complement of the even syndrome, `status` is 2'b01 (data fix). `fix_addr` is odd syndrome bits [11:3] and `fix_mask` is a one-hot byte with bit odd[2:0] set.
- R5: A data fix reads byte `fix_addr`, then on the next cycle writes back the read value XOR `fix_mask` to the same address. No other byte of the buffer changes.
- R6: Otherwise, if the OR of the two syndromes has exactly one bit set, `status` is 2'b10 (parity only) and the buffer is not written. This applies even when both syndromes hold the same single bit.
- R7: Every other syndrome pair gives `status` 2'b11 (uncorrectable), and the buffer is not written.
- R8: `done` is a one-cycle pulse. It appears in the second cycle after `start` is sampled for outcomes that need no write, and in the third cycle for a data fix.
- R9: `start` is ignored while `busy` is high. A second request sent during a job neither changes that job's outcome nor produces a second `done`.
- R10: `corr_cnt` increments once for each job ending in 2'b01 or 2'b10. `fail_cnt` increments once for each job ending in 2'b11.
- R11: A `cnt_clr` pulse zeroes both counters on the next cycle. It takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job using the codes presented in the same cycle |
| stored_code | input | 24 | Code read from the spare area, in complemented form |
| calc_code | input | 24 | Code computed over the chunk as read |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: the job has finished and `status` is valid |
| status | output | 2 | 00 clean, 01 data fix, 10 parity only, 11 uncorrectable |
| fix_addr | output | 9 | Byte offset of the repaired bit (data fix only) |
| fix_mask | output | 8 | One-hot mask of the repaired bit (data fix only) |
| mem_rd | output | 1 | Buffer read strobe; data is returned one cycle later |
| mem_wr | output | 1 | Buffer write strobe |
| mem_addr | output | 9 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data |
| cnt_clr | input | 1 | Clear pulse for both counters |
| corr_cnt | output | 16 | Number of repaired errors |
| fail_cnt | output | 16 | Number of uncorrectable chunks |

## Verification
The bench aims at the ends of the address range: byte 0 bit 0 (odd syndrome all zeros) and byte 511 bit 7 (odd syndrome all ones). A design that mixed up the halves or got the bit slice wrong would flip the wrong byte, and the full buffer image compare would show it. It also sends the case where both syndromes hold the same single bit, and the case where both are all ones. The first must be treated as parity only and the second as uncorrectable. If the complement of the kept code were dropped, these cases would be misclassified, and so would every clean chunk. Last, the bench sends a second request while a repair is under way, and pulses a clear in the same cycle as a counter increment. These expose a design that restarts mid-job or lets the increment win over the clear.

// File: rtl/ecc_corr_pkg.sv
package ecc_corr_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_DATA_FIX = 2'b01,
    ST_PARITY   = 2'b10,
    ST_UNCORR   = 2'b11
  } ecc_status_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_EVAL,
    PH_WRITE,
    PH_FINISH
  } rmw_phase_e;

endpackage

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode
  import ecc_corr_pkg::*;
#(
  parameter int CODE_W          = 24,
  parameter bit STORED_INVERTED = 1'b1
) (
  input  logic [CODE_W-1:0]         stored_code,
  input  logic [CODE_W-1:0]         calc_code,
  output ecc_status_e               verdict,
  output logic [CODE_W/2-4:0]       byte_addr,
  output logic [7:0]                bit_mask,
  output logic [CODE_W/2-1:0]       odd_syn,
  output logic [CODE_W/2-1:0]       even_syn
);

  localparam int HALF_W = CODE_W / 2;

  logic [CODE_W-1:0] ref_code;

  // Whether the kept code needs complementing is a build-time variant
  generate
    if (STORED_INVERTED) begin : g_inv
      assign ref_code = ~stored_code;
    end else begin : g_plain
      assign ref_code = stored_code;
    end
  endgenerate

  function automatic logic single_bit(input logic [HALF_W-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

  function automatic ecc_status_e classify(input logic [HALF_W-1:0] o,
                                           input logic [HALF_W-1:0] e);
    if ((o == '0) && (e == '0)) return ST_CLEAN;
    if (o == ~e)                return ST_DATA_FIX;
    if (single_bit(o | e))      return ST_PARITY;
    return ST_UNCORR;
  endfunction

  function automatic logic [7:0] mask_of(input logic [2:0] b);
    return 8'(1) << b;
  endfunction

  assign odd_syn   = ref_code[HALF_W-1:0]      ^ calc_code[HALF_W-1:0];
  assign even_syn  = ref_code[CODE_W-1:HALF_W] ^ calc_code[CODE_W-1:HALF_W];
  assign verdict   = classify(odd_syn, even_syn);
  assign byte_addr = odd_syn[HALF_W-1:3];
  assign bit_mask  = mask_of(odd_syn[2:0]);

endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_corr_pkg::*;
#(
  parameter int BYTE_AW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  ecc_status_e        verdict,
  input  logic [BYTE_AW-1:0] dec_addr,
  input  logic [7:0]         dec_mask,
  input  logic [7:0]         mem_rdata,
  output logic               accept,
  output logic               busy,
  output logic               done,
  output ecc_status_e        status,
  output logic [BYTE_AW-1:0] fix_addr,
  output logic [7:0]         fix_mask,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [BYTE_AW-1:0] mem_addr,
  output logic [7:0]         mem_wdata
);

  rmw_phase_e         phase;
  ecc_status_e        status_q;
  logic [BYTE_AW-1:0] addr_q;
  logic [7:0]         mask_q;
  logic               is_fix;

  assign is_fix = (verdict == ST_DATA_FIX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      status_q <= ST_CLEAN;
      addr_q   <= '0;
      mask_q   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) phase <= PH_EVAL;
        PH_EVAL: begin
          status_q <= verdict;
          addr_q   <= is_fix ? dec_addr : '0;
          mask_q   <= is_fix ? dec_mask : '0;
          phase    <= is_fix ? PH_WRITE : PH_FINISH;
        end
        PH_WRITE:  phase <= PH_FINISH;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  assign accept    = (phase == PH_IDLE) && start;
  assign busy      = (phase != PH_IDLE);
  assign done      = (phase == PH_FINISH);
  assign status    = status_q;
  assign fix_addr  = addr_q;
  assign fix_mask  = mask_q;
  assign mem_rd    = (phase == PH_EVAL) && is_fix;
  assign mem_wr    = (phase == PH_WRITE);
  assign mem_addr  = (phase == PH_EVAL) ? dec_addr : addr_q;
  assign mem_wdata = mem_rdata ^ mask_q;

endmodule

// File: rtl/ecc_err_tally.sv
module ecc_err_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (bump) count <= count + 1'b1;
  end

endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
  import ecc_corr_pkg::*;
#(
  parameter int CODE_W          = 24,
  parameter int CNT_W           = 16,
  parameter bit STORED_INVERTED = 1'b1,
  localparam int BYTE_AW        = CODE_W / 2 - 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CODE_W-1:0]  stored_code,
  input  logic [CODE_W-1:0]  calc_code,
  output logic               busy,
  output logic               done,
  output logic [1:0]         status,
  output logic [BYTE_AW-1:0] fix_addr,
  output logic [7:0]         fix_mask,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [BYTE_AW-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  input  logic               cnt_clr,
  output logic [CNT_W-1:0]   corr_cnt,
  output logic [CNT_W-1:0]   fail_cnt
);

  localparam int HALF_W  = CODE_W / 2;
  localparam int N_TALLY = 2;

  logic [CODE_W-1:0]  stored_q, calc_q;
  ecc_status_e        verdict, status_e;
  logic [BYTE_AW-1:0] dec_addr;
  logic [7:0]         dec_mask;
  logic [HALF_W-1:0]  odd_syn, even_syn;

  // Named events, brought out for the checker
  logic accept_evt;
  logic fix_evt;
  logic finish_evt;
  logic [N_TALLY-1:0] tally_bump;
  logic [CNT_W-1:0]   tally_cnt [N_TALLY];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_q <= '0;
      calc_q   <= '0;
    end else if (accept_evt) begin
      stored_q <= stored_code;
      calc_q   <= calc_code;
    end
  end

  ecc_syndrome_decode #(
    .CODE_W          (CODE_W),
    .STORED_INVERTED (STORED_INVERTED)
  ) dec_i (
    .stored_code (stored_q),
    .calc_code   (calc_q),
    .verdict     (verdict),
    .byte_addr   (dec_addr),
    .bit_mask    (dec_mask),
    .odd_syn     (odd_syn),
    .even_syn    (even_syn)
  );

  ecc_rmw_ctrl #(.BYTE_AW(BYTE_AW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .verdict   (verdict),
    .dec_addr  (dec_addr),
    .dec_mask  (dec_mask),
    .mem_rdata (mem_rdata),
    .accept    (accept_evt),
    .busy      (busy),
    .done      (finish_evt),
    .status    (status_e),
    .fix_addr  (fix_addr),
    .fix_mask  (fix_mask),
    .mem_rd    (mem_rd),
    .mem_wr    (fix_evt),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign done   = finish_evt;
  assign mem_wr = fix_evt;
  assign status = status_e;

  assign tally_bump[0] = finish_evt &&
                         ((status_e == ST_DATA_FIX) || (status_e == ST_PARITY));
  assign tally_bump[1] = finish_evt && (status_e == ST_UNCORR);

  generate
    for (genvar t = 0; t < N_TALLY; t++) begin : g_tally
      ecc_err_tally #(.CNT_W(CNT_W)) tally_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .bump  (tally_bump[t]),
        .count (tally_cnt[t])
      );
    end
  endgenerate

  assign corr_cnt = tally_cnt[0];
  assign fail_cnt = tally_cnt[1];

endmodule

// File: rtl/ecc_corrector_chk.sv
module ecc_corrector_chk #(
  parameter int CNT_W   = 16,
  parameter int BYTE_AW = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic [1:0]         status,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic [BYTE_AW-1:0] mem_addr,
  input logic               cnt_clr,
  input logic [CNT_W-1:0]   corr_cnt,
  input logic [CNT_W-1:0]   fail_cnt,
  input logic               accept_evt
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  // R5
  wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == $past(mem_addr)));

  // R5
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R4
  fix_wrote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b01) |-> $past(mem_wr));

  // R6
  nofix_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'b01) |-> !$past(mem_wr));

  // R9
  single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !accept_evt);

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (corr_cnt == '0 && fail_cnt == '0));

  // R10
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !(done && status == 2'b11)) |=> (fail_cnt == $past(fail_cnt)));

endmodule

bind ecc_corrector ecc_corrector_chk #(.CNT_W(CNT_W), .BYTE_AW(BYTE_AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .status     (status),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .cnt_clr    (cnt_clr),
  .corr_cnt   (corr_cnt),
  .fail_cnt   (fail_cnt),
  .accept_evt (accept_evt)
);

// File: tb/ecc_corrector_tb_top.sv
module ecc_corrector_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        busy, done, mem_rd, mem_wr;
  logic [1:0]  status;
  logic [8:0]  fix_addr, mem_addr;
  logic [7:0]  fix_mask, mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        cnt_clr = 1'b0;
  logic [15:0] corr_cnt, fail_cnt;

  int checks = 0, failures = 0;
  int wr_count = 0;
  int exp_corr = 0, exp_fail = 0;
  bit finished = 0;
  logic [7:0] mem     [512];
  logic [7:0] exp_mem [512];

  always #10 clk = ~clk;

  ecc_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .stored_code(stored_code), .calc_code(calc_code),
    .busy(busy), .done(done), .status(status),
    .fix_addr(fix_addr), .fix_mask(fix_mask),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cnt_clr(cnt_clr), .corr_cnt(corr_cnt), .fail_cnt(fail_cnt)
  );

  // Buffer model: one cycle of read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) begin
      mem[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(req, "buffer bytes differing", bad, 0);
  endtask

  task automatic chk_counters(input string req);
    chk(req, "corr_cnt", corr_cnt, exp_corr);
    chk(req, "fail_cnt", fail_cnt, exp_fail);
  endtask

  // Builds codes so that the syndromes seen after inverting the kept code are
  // exactly odd_e / even_e (R2), then runs one job and checks it.
  task automatic run_case(input string req, input logic [11:0] odd_e,
                          input logic [11:0] even_e, input logic [1:0] exp_st,
                          input logic [23:0] seed);
    int lat = 0;
    int w0 = wr_count;
    logic [23:0] c = seed;
    @(negedge clk);
    start = 1'b1;
    calc_code = c;
    stored_code = ~(c ^ {even_e, odd_e});
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk(req, "status", status, exp_st);
    chk("R8", "done latency", lat, (exp_st == 2'b01) ? 2 : 1);
    if (exp_st == 2'b01) begin
      chk("R4", "fix_addr", fix_addr, odd_e[11:3]);
      chk("R4", "fix_mask", fix_mask, 8'(1) << odd_e[2:0]);
      exp_mem[odd_e[11:3]] = exp_mem[odd_e[11:3]] ^ (8'(1) << odd_e[2:0]);
    end
    if (exp_st == 2'b01 || exp_st == 2'b10) exp_corr++;
    if (exp_st == 2'b11) exp_fail++;
    @(negedge clk);
    chk("R8", "done after pulse", done, 0);
    @(negedge clk);
    chk(req, "buffer writes", wr_count - w0, (exp_st == 2'b01) ? 1 : 0);
    chk_mem(req);
    chk_counters("R10");
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "mem_rd", mem_rd, 0);
    chk("R1", "mem_wr", mem_wr, 0);
    chk("R1", "status", status, 0);
    chk_counters("R1");
  endtask

  task automatic t_busy_ignore();
    int dones = 0;
    int w0 = wr_count;
    logic [11:0] o = 12'h51B;
    logic [23:0] c = 24'h13579B;
    @(negedge clk);
    start = 1'b1;
    calc_code = c;
    stored_code = ~(c ^ {~o, o});
    @(negedge clk);
    // second request (would be uncorrectable) while busy
    calc_code = 24'h0;
    stored_code = ~{12'h0F0, 12'h00F};
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (done) begin
        dones++;
        chk("R9", "status of first job", status, 2'b01);
      end
      @(negedge clk);
    end
    exp_mem[o[11:3]] = exp_mem[o[11:3]] ^ (8'(1) << o[2:0]);
    exp_corr++;
    chk("R9", "done pulses", dones, 1);
    chk("R9", "buffer writes", wr_count - w0, 1);
    chk_mem("R9");
    chk_counters("R9");
  endtask

  task automatic t_clear();
    int lat = 0;
    @(negedge clk);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    exp_corr = 0;
    exp_fail = 0;
    chk_counters("R11");
    // clear in the same cycle as an increment: clear wins
    start = 1'b1;
    calc_code = 24'h0;
    stored_code = ~{12'h000, 12'h400};
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk("R6", "status", status, 2'b10);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    chk_counters("R11");
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'((i * 7 + 3) & 8'hFF);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("R3", 12'h000, 12'h000, 2'b00, 24'hA5C3F0);
    run_case("R5", 12'hD2E, 12'h2D1, 2'b01, 24'h3C3C3C);
    run_case("R5", 12'h000, 12'hFFF, 2'b01, 24'h123456);
    run_case("R5", 12'hFFF, 12'h000, 2'b01, 24'hFEDCBA);
    run_case("R6", 12'h000, 12'h040, 2'b10, 24'h0F0F0F);
    run_case("R6", 12'h800, 12'h000, 2'b10, 24'h777777);
    run_case("R6", 12'h001, 12'h001, 2'b10, 24'h246813);
    run_case("R7", 12'h00F, 12'h0F0, 2'b11, 24'h998877);
    run_case("R2", 12'hFFF, 12'hFFF, 2'b11, 24'h55AA55);
    t_busy_ignore();
    t_clear();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule